// File: doc/BRIEF.md
# Burst-Fetch Vector Multiply Engine

This engine is a start/done accelerator that multiplies two eight-word vectors element by element and writes the products back to memory. When the idle engine sees a start pulse, it captures three byte offsets from plain input ports: operand A, operand B and the result. It then requests an eight-beat read burst on each of two AXI4 read-master ports and an eight-beat write burst on an AXI4 write-master port. Once all three requests have been accepted, a streaming loop takes one operand pair per clock. The loop multiplies the pair and pushes the product onto the write-data channel.

The loop is a three-register pipeline: operand capture, product, write beat. It advances as a whole whenever the write-data register is empty or being accepted. If either read port has no data in a cycle, an empty slot enters instead of a beat. After the eighth beat the engine waits on the write-response channel. It then gives a one-cycle done pulse and raises a level interrupt that stays up until the next start.

States:
- `ST_IDLE`: waiting for start.
- `ST_REQ`: issuing the three address requests.
- `ST_LOOP`: streaming.
- `ST_RESP`: waiting for the write response.
- `ST_FIN`: done pulse.

Transitions:
- IDLE→REQ on start.
- REQ→LOOP once every address request has been accepted.
- LOOP→RESP once eight beats have been written.
- RESP→FIN on a write-response handshake.
- FIN→IDLE unconditionally.

Top module: `vmul_engine`

## Requirements
- R1: A start pulse in idle captures the three offsets. Changes to the offset inputs after that cycle have no effect on the run.
- R2: Each emitted burst address equals its captured offset with bits 1:0 forced to zero.
- R3: After start, exactly one read request is issued on each read port with length field 7 (eight beats), size field 2 (four bytes) and burst field 2'b01 (incrementing). Each request valid stays high until accepted.
- R4: Exactly one write request is issued, with the same length, size and burst encodings and a stable address while not accepted. No write data is sent before the write request, and neither read request, has been accepted.
- R5: Read beats are consumed only in cycles where both read ports present data, with both ready signals asserted together. Under random delays on every channel, no beat is lost or duplicated.
- R6: Result word k is stored at result offset + 4k, and equals the low 32 bits of the signed product A[k]×B[k].
- R7: Exactly eight write beats are sent per run, each with byte strobes 4'b1111. The last-beat flag is set on the eighth beat only.
- R8: A write beat not accepted keeps its valid and data unchanged in the next cycle.
- R9: The response ready is raised only after the eighth beat. Done is high for exactly one cycle, the cycle after the write-response handshake, and idle returns in the following cycle.
- R10: The interrupt output rises together with done and stays high until the next start is accepted.
- R11: After reset, idle is high and done, interrupt and all request and write valids are low. Idle is low from the cycle after start until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a run when idle |
| idle | output | 1 | Engine is waiting for start |
| done | output | 1 | One-cycle completion pulse |
| irq | output | 1 | Completion interrupt, cleared by start |
| a_base | input | 32 | Byte offset of operand A |
| b_base | input | 32 | Byte offset of operand B |
| r_base | input | 32 | Byte offset of the result |
| a_arvalid | output | 1 | A read request valid |
| a_arready | input | 1 | A read request accepted |
| a_araddr | output | 32 | A burst address |
| a_arlen | output | 8 | A burst length minus one |
| a_arsize | output | 3 | A beat size code |
| a_arburst | output | 2 | A burst type |
| a_rvalid | input | 1 | A read data valid |
| a_rready | output | 1 | A read data taken |
| a_rdata | input | 32 | A read data |
| b_arvalid | output | 1 | B read request valid |
| b_arready | input | 1 | B read request accepted |
| b_araddr | output | 32 | B burst address |
| b_arlen | output | 8 | B burst length minus one |
| b_arsize | output | 3 | B beat size code |
| b_arburst | output | 2 | B burst type |
| b_rvalid | input | 1 | B read data valid |
| b_rready | output | 1 | B read data taken |
| b_rdata | input | 32 | B read data |
| r_awvalid | output | 1 | Write request valid |
| r_awready | input | 1 | Write request accepted |
| r_awaddr | output | 32 | Write burst address |
| r_awlen | output | 8 | Write burst length minus one |
| r_awsize | output | 3 | Write beat size code |
| r_awburst | output | 2 | Write burst type |
| r_wvalid | output | 1 | Write beat valid |
| r_wready | input | 1 | Write beat accepted |
| r_wdata | output | 32 | Product word |
| r_wstrb | output | 4 | Byte strobes |
| r_wlast | output | 1 | Last beat of the burst |
| r_bvalid | input | 1 | Write response valid |
| r_bready | output | 1 | Write response taken |

## Verification
The memory models watch every handshake at the falling edge that follows the rising edge on which it happened. The done and interrupt checks are made at the same falling edge where the model registers the write-response handshake, because the engine enters `ST_FIN` on that rising edge. Idle is then checked one falling edge later. Write beats leave the pipeline two rising edges after their operand pair was taken from the read ports. For this reason, the bench compares results only after the response handshake, when all eight beats must already be in the result memory. The per-beat strobe and last-flag checks are made on each write handshake as it occurs.

// File: rtl/vmul_pkg.sv
package vmul_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_LOOP,
        ST_RESP,
        ST_FIN
    } vm_state_e;

    localparam logic [1:0] BURST_INCR = 2'b01;

endpackage

// File: rtl/vmul_ctrl.sv
module vmul_ctrl
    import vmul_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic a_arready,
    input  logic b_arready,
    input  logic awready,
    input  logic all_written,
    input  logic bvalid,
    output logic cap,
    output logic idle,
    output logic done,
    output logic irq,
    output logic a_arvalid,
    output logic b_arvalid,
    output logic awvalid,
    output logic loop_en,
    output logic bready
);

    vm_state_e st_q, st_d;
    logic      a_ok_q, b_ok_q, aw_ok_q;
    logic      req_all;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Per-request acceptance flags, cleared on each new run
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_ok_q  <= 1'b0;
            b_ok_q  <= 1'b0;
            aw_ok_q <= 1'b0;
        end else if (cap) begin
            a_ok_q  <= 1'b0;
            b_ok_q  <= 1'b0;
            aw_ok_q <= 1'b0;
        end else begin
            if (a_arvalid && a_arready) a_ok_q  <= 1'b1;
            if (b_arvalid && b_arready) b_ok_q  <= 1'b1;
            if (awvalid && awready)     aw_ok_q <= 1'b1;
        end
    end

    assign req_all = (a_ok_q || a_arready) && (b_ok_q || b_arready) && (aw_ok_q || awready);

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start)       st_d = ST_REQ;
            ST_REQ:  if (req_all)     st_d = ST_LOOP;
            ST_LOOP: if (all_written) st_d = ST_RESP;
            ST_RESP: if (bvalid)      st_d = ST_FIN;
            ST_FIN:                   st_d = ST_IDLE;
            default:                  st_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        cap       = (st_q == ST_IDLE) && start;
        idle      = (st_q == ST_IDLE);
        done      = (st_q == ST_FIN);
        a_arvalid = (st_q == ST_REQ) && !a_ok_q;
        b_arvalid = (st_q == ST_REQ) && !b_ok_q;
        awvalid   = (st_q == ST_REQ) && !aw_ok_q;
        loop_en   = (st_q == ST_LOOP);
        bready    = (st_q == ST_RESP);
    end

    // Interrupt: set with completion, cleared by the next accepted start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          irq <= 1'b0;
        else if (cap)                        irq <= 1'b0;
        else if (st_q == ST_RESP && bvalid)  irq <= 1'b1;
    end

    AST_AR_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        a_arvalid && !a_arready |=> a_arvalid); // R3
    AST_AR_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        b_arvalid && !b_arready |=> b_arvalid); // R3
    AST_DONE_AFTER_B: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bvalid && bready)); // R9
    AST_IRQ_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> done); // R10

endmodule

// File: rtl/vmul_pipe.sv
module vmul_pipe #(
    parameter int DW  = 32,
    parameter int NUM = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          loop_en,
    input  logic          a_rvalid,
    input  logic [DW-1:0] a_rdata,
    input  logic          b_rvalid,
    input  logic [DW-1:0] b_rdata,
    input  logic          wready,
    output logic          rready,
    output logic          wvalid,
    output logic [DW-1:0] wdata,
    output logic          wlast,
    output logic          all_written
);

    localparam int CW = $clog2(NUM + 1);

    logic [CW-1:0] fcnt_q, wcnt_q;
    logic          adv, take;
    logic          s1_v, s2_v, w_v;
    logic [DW-1:0] s1_a, s1_b, s2_p, w_d;

    // Whole pipeline moves when the write register is free or draining
    assign adv  = !w_v || wready;
    assign take = loop_en && (fcnt_q != CW'(NUM)) && adv && a_rvalid && b_rvalid;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fcnt_q <= '0;
            wcnt_q <= '0;
            s1_v   <= 1'b0;
            s2_v   <= 1'b0;
            w_v    <= 1'b0;
        end else if (clr) begin
            fcnt_q <= '0;
            wcnt_q <= '0;
            s1_v   <= 1'b0;
            s2_v   <= 1'b0;
            w_v    <= 1'b0;
        end else begin
            if (take)          fcnt_q <= fcnt_q + 1'b1;
            if (w_v && wready) wcnt_q <= wcnt_q + 1'b1;
            if (adv) begin
                s1_v <= take;
                s2_v <= s1_v;
                w_v  <= s2_v;
            end
        end
    end

    // Data registers carry no reset; their valid bits qualify them
    always_ff @(posedge clk) begin
        if (adv) begin
            if (take) begin
                s1_a <= a_rdata;
                s1_b <= b_rdata;
            end
            s2_p <= DW'($signed(s1_a) * $signed(s1_b));
            w_d  <= s2_p;
        end
    end

    assign rready      = take;
    assign wvalid      = w_v;
    assign wdata       = w_d;
    assign wlast       = w_v && (wcnt_q == CW'(NUM - 1));
    assign all_written = (wcnt_q == CW'(NUM));

    AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && !wready |=> wvalid && $stable(wdata)); // R8
    AST_WLAST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        wvalid && wready && wlast |=> !wvalid); // R7

endmodule

// File: rtl/vmul_engine.sv
module vmul_engine
    import vmul_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int NUM = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            idle,
    output logic            done,
    output logic            irq,
    input  logic [AW-1:0]   a_base,
    input  logic [AW-1:0]   b_base,
    input  logic [AW-1:0]   r_base,
    output logic            a_arvalid,
    input  logic            a_arready,
    output logic [AW-1:0]   a_araddr,
    output logic [7:0]      a_arlen,
    output logic [2:0]      a_arsize,
    output logic [1:0]      a_arburst,
    input  logic            a_rvalid,
    output logic            a_rready,
    input  logic [DW-1:0]   a_rdata,
    output logic            b_arvalid,
    input  logic            b_arready,
    output logic [AW-1:0]   b_araddr,
    output logic [7:0]      b_arlen,
    output logic [2:0]      b_arsize,
    output logic [1:0]      b_arburst,
    input  logic            b_rvalid,
    output logic            b_rready,
    input  logic [DW-1:0]   b_rdata,
    output logic            r_awvalid,
    input  logic            r_awready,
    output logic [AW-1:0]   r_awaddr,
    output logic [7:0]      r_awlen,
    output logic [2:0]      r_awsize,
    output logic [1:0]      r_awburst,
    output logic            r_wvalid,
    input  logic            r_wready,
    output logic [DW-1:0]   r_wdata,
    output logic [DW/8-1:0] r_wstrb,
    output logic            r_wlast,
    input  logic            r_bvalid,
    output logic            r_bready
);

    localparam int          BYTES      = DW / 8;
    localparam int          OFFB       = $clog2(BYTES);
    localparam int          NBASE      = 3;
    localparam logic [7:0]  LEN_CODE   = 8'(NUM - 1);
    localparam logic [2:0]  SIZE_CODE  = 3'(OFFB);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'((1 << OFFB) - 1);

    logic          cap, loop_en, all_written, rready;
    logic [AW-1:0] base_in [NBASE];
    logic [AW-1:0] base_q  [NBASE];

    assign base_in[0] = a_base;
    assign base_in[1] = b_base;
    assign base_in[2] = r_base;

    // One capture register per offset, loaded on the accepted start
    for (genvar g = 0; g < NBASE; g++) begin : g_base
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   base_q[g] <= '0;
            else if (cap) base_q[g] <= base_in[g];
        end
    end

    vmul_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .a_arready   (a_arready),
        .b_arready   (b_arready),
        .awready     (r_awready),
        .all_written (all_written),
        .bvalid      (r_bvalid),
        .cap         (cap),
        .idle        (idle),
        .done        (done),
        .irq         (irq),
        .a_arvalid   (a_arvalid),
        .b_arvalid   (b_arvalid),
        .awvalid     (r_awvalid),
        .loop_en     (loop_en),
        .bready      (r_bready)
    );

    vmul_pipe #(.DW(DW), .NUM(NUM)) u_pipe (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr         (cap),
        .loop_en     (loop_en),
        .a_rvalid    (a_rvalid),
        .a_rdata     (a_rdata),
        .b_rvalid    (b_rvalid),
        .b_rdata     (b_rdata),
        .wready      (r_wready),
        .rready      (rready),
        .wvalid      (r_wvalid),
        .wdata       (r_wdata),
        .wlast       (r_wlast),
        .all_written (all_written)
    );

    assign a_rready  = rready;
    assign b_rready  = rready;

    assign a_araddr  = base_q[0] & ALIGN_MASK;
    assign b_araddr  = base_q[1] & ALIGN_MASK;
    assign r_awaddr  = base_q[2] & ALIGN_MASK;

    assign a_arlen   = LEN_CODE;
    assign b_arlen   = LEN_CODE;
    assign r_awlen   = LEN_CODE;
    assign a_arsize  = SIZE_CODE;
    assign b_arsize  = SIZE_CODE;
    assign r_awsize  = SIZE_CODE;
    assign a_arburst = BURST_INCR;
    assign b_arburst = BURST_INCR;
    assign r_awburst = BURST_INCR;
    assign r_wstrb   = '1;

    AST_AW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        r_awvalid && !r_awready |=> r_awvalid && $stable(r_awaddr)); // R4
    AST_AR_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        a_arvalid && !a_arready |=> $stable(a_araddr)); // R3
    AST_NO_EARLY_WDATA: assert property (@(posedge clk) disable iff (!rst_n)
        r_wvalid |-> !r_awvalid && !a_arvalid && !b_arvalid); // R4

endmodule

// File: tb/test_vmul_engine.sv
module test_vmul_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NUM        = 8;
    localparam int WD_LIMIT   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] a_base = '0, b_base = '0, r_base = '0;
    logic        a_arready = 1'b0, b_arready = 1'b0, r_awready = 1'b0;
    logic        a_rvalid = 1'b0, b_rvalid = 1'b0, r_wready = 1'b0, r_bvalid = 1'b0;
    logic [31:0] a_rdata = '0, b_rdata = '0;

    logic        idle, done, irq;
    logic        a_arvalid, b_arvalid, r_awvalid, a_rready, b_rready;
    logic        r_wvalid, r_wlast, r_bready;
    logic [31:0] a_araddr, b_araddr, r_awaddr, r_wdata;
    logic [7:0]  a_arlen, b_arlen, r_awlen;
    logic [2:0]  a_arsize, b_arsize, r_awsize;
    logic [1:0]  a_arburst, b_arburst, r_awburst;
    logic [3:0]  r_wstrb;

    vmul_engine i_vmul_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .idle(idle), .done(done), .irq(irq),
        .a_base(a_base), .b_base(b_base), .r_base(r_base),
        .a_arvalid(a_arvalid), .a_arready(a_arready), .a_araddr(a_araddr),
        .a_arlen(a_arlen), .a_arsize(a_arsize), .a_arburst(a_arburst),
        .a_rvalid(a_rvalid), .a_rready(a_rready), .a_rdata(a_rdata),
        .b_arvalid(b_arvalid), .b_arready(b_arready), .b_araddr(b_araddr),
        .b_arlen(b_arlen), .b_arsize(b_arsize), .b_arburst(b_arburst),
        .b_rvalid(b_rvalid), .b_rready(b_rready), .b_rdata(b_rdata),
        .r_awvalid(r_awvalid), .r_awready(r_awready), .r_awaddr(r_awaddr),
        .r_awlen(r_awlen), .r_awsize(r_awsize), .r_awburst(r_awburst),
        .r_wvalid(r_wvalid), .r_wready(r_wready), .r_wdata(r_wdata),
        .r_wstrb(r_wstrb), .r_wlast(r_wlast),
        .r_bvalid(r_bvalid), .r_bready(r_bready)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    bit stress  = 1'b0;

    logic [31:0] mem_a [256];
    logic [31:0] mem_b [256];
    logic [31:0] mem_r [256];

    // per-run observations made by the memory models
    int          n_ar_a, n_ar_b, n_aw, n_beats, n_b, n_done;
    logic [31:0] seen_a_addr, seen_b_addr, seen_r_addr;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit coin(input int pct);
        if (!stress) return 1'b1;
        return int'($urandom % 100) < pct;
    endfunction

    function automatic logic [31:0] ref_mul(input logic [31:0] x, input logic [31:0] y);
        logic signed [63:0] full;
        full = $signed(x) * $signed(y);
        return full[31:0];
    endfunction

    function automatic logic [31:0] edge_a(input int k);
        case (k)
            0: return 32'h8000_0000; 1: return 32'hFFFF_FFFF; 2: return 32'h7FFF_FFFF;
            3: return 32'h0000_0000; 4: return 32'h8000_0000; 5: return 32'h0000_0001;
            6: return 32'hFFFF_0000; default: return 32'h1234_5678;
        endcase
    endfunction

    function automatic logic [31:0] edge_b(input int k);
        case (k)
            0: return 32'hFFFF_FFFF; 1: return 32'hFFFF_FFFF; 2: return 32'h0000_0002;
            3: return 32'h0000_DEAD; 4: return 32'h8000_0000; 5: return 32'hFFFF_FFFF;
            6: return 32'h0001_0001; default: return 32'h9ABC_DEF0;
        endcase
    endfunction

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // watchdog
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc >= WD_LIMIT) begin
                n_tests++;
                n_fail++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
                $finish;
            end
        end
    end

    // Memory models: handshakes are judged from the values seen before the last rising edge
    initial begin
        logic       sv_aarv, sv_barv, sv_awv, sv_ar_r, sv_br_r, sv_wv, sv_wl, sv_brdy;
        logic [31:0] sv_aaddr, sv_baddr, sv_waddr, sv_wd;
        logic [7:0]  sv_alen, sv_blen, sv_wlen;
        logic [2:0]  sv_asz, sv_bsz, sv_wsz;
        logic [1:0]  sv_abt, sv_bbt, sv_wbt;
        logic [3:0]  sv_ws;
        logic [7:0]  a_ptr, b_ptr, w_ptr;
        int          a_left, b_left;
        bit          b_given;
        sv_aarv = 0; sv_barv = 0; sv_awv = 0; sv_ar_r = 0; sv_br_r = 0;
        sv_wv = 0; sv_wl = 0; sv_brdy = 0;
        sv_aaddr = 0; sv_baddr = 0; sv_waddr = 0; sv_wd = 0;
        sv_alen = 0; sv_blen = 0; sv_wlen = 0; sv_asz = 0; sv_bsz = 0; sv_wsz = 0;
        sv_abt = 0; sv_bbt = 0; sv_wbt = 0; sv_ws = 0;
        a_ptr = 0; b_ptr = 0; w_ptr = 0; a_left = 0; b_left = 0; b_given = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                a_arready = 0; b_arready = 0; r_awready = 0; a_rvalid = 0; b_rvalid = 0;
                r_wready = 0; r_bvalid = 0; a_left = 0; b_left = 0; b_given = 0;
            end else begin
                if (done) n_done++;
                // read port A
                if (sv_aarv && a_arready) begin
                    n_ar_a++; seen_a_addr = sv_aaddr; a_ptr = sv_aaddr[9:2]; a_left = NUM;
                    chk(sv_alen == 8'd7 && sv_asz == 3'd2 && sv_abt == 2'b01, "R3 A request fields",
                        {19'd0, sv_alen, sv_asz, sv_abt}, {19'd0, 8'd7, 3'd2, 2'b01});
                end
                if (a_rvalid && sv_ar_r) begin a_ptr++; a_left--; a_rvalid = 0; end
                if (!a_rvalid && a_left > 0 && coin(60)) begin a_rvalid = 1; a_rdata = mem_a[a_ptr]; end
                // read port B
                if (sv_barv && b_arready) begin
                    n_ar_b++; seen_b_addr = sv_baddr; b_ptr = sv_baddr[9:2]; b_left = NUM;
                    chk(sv_blen == 8'd7 && sv_bsz == 3'd2 && sv_bbt == 2'b01, "R3 B request fields",
                        {19'd0, sv_blen, sv_bsz, sv_bbt}, {19'd0, 8'd7, 3'd2, 2'b01});
                end
                if (b_rvalid && sv_br_r) begin b_ptr++; b_left--; b_rvalid = 0; end
                if (!b_rvalid && b_left > 0 && coin(55)) begin b_rvalid = 1; b_rdata = mem_b[b_ptr]; end
                if (sv_ar_r != sv_br_r)
                    chk(0, "R5 ready pairing", {31'd0, sv_ar_r}, {31'd0, sv_br_r});
                // write port
                if (sv_awv && r_awready) begin
                    n_aw++; seen_r_addr = sv_waddr; w_ptr = sv_waddr[9:2];
                    chk(sv_wlen == 8'd7 && sv_wsz == 3'd2 && sv_wbt == 2'b01, "R4 write request fields",
                        {19'd0, sv_wlen, sv_wsz, sv_wbt}, {19'd0, 8'd7, 3'd2, 2'b01});
                end
                if (sv_wv && r_wready) begin
                    if (n_aw == 0 || n_ar_a == 0 || n_ar_b == 0)
                        chk(0, "R4 data before requests accepted", 32'(n_aw), 32'd1);
                    mem_r[w_ptr] = sv_wd;
                    chk(sv_ws == 4'hF, "R7 strobes", {28'd0, sv_ws}, 32'hF);
                    chk(sv_wl == (n_beats == NUM - 1), "R7 last flag", {31'd0, sv_wl},
                        {31'd0, n_beats == NUM - 1});
                    w_ptr++; n_beats++;
                end
                if (r_bvalid && sv_brdy) begin
                    r_bvalid = 0; n_b++;
                    chk(done == 1'b1, "R9 done after response", {31'd0, done}, 32'd1);
                    chk(irq == 1'b1, "R10 irq with done", {31'd0, irq}, 32'd1);
                end
                if (sv_brdy && n_beats < NUM)
                    chk(0, "R9 response ready early", 32'(n_beats), 32'(NUM));
                if (!r_bvalid && !b_given && n_beats == NUM && coin(40)) begin
                    r_bvalid = 1; b_given = 1;
                end
                if (idle) b_given = 0;
                a_arready = coin(50); b_arready = coin(45); r_awready = coin(50);
                r_wready  = coin(60);
            end
            #1;
            sv_aarv = a_arvalid; sv_aaddr = a_araddr; sv_alen = a_arlen; sv_asz = a_arsize; sv_abt = a_arburst;
            sv_barv = b_arvalid; sv_baddr = b_araddr; sv_blen = b_arlen; sv_bsz = b_arsize; sv_bbt = b_arburst;
            sv_awv  = r_awvalid; sv_waddr = r_awaddr; sv_wlen = r_awlen; sv_wsz = r_awsize; sv_wbt = r_awburst;
            sv_ar_r = a_rready; sv_br_r = b_rready;
            sv_wv = r_wvalid; sv_wd = r_wdata; sv_ws = r_wstrb; sv_wl = r_wlast; sv_brdy = r_bready;
        end
    end

    task automatic run_vec(input int kind, input bit first);
        int          ai, bi, ri, guard;
        logic [31:0] ea, eb, er;
        ai = int'($urandom % 249); bi = int'($urandom % 249); ri = int'($urandom % 249);
        for (int k = 0; k < NUM; k++) begin
            mem_a[ai + k] = (kind == 1) ? edge_a(k) : $urandom;
            mem_b[bi + k] = (kind == 1) ? edge_b(k) : $urandom;
            mem_r[ri + k] = 32'hDEAD_BEEF;
        end
        ea = {$urandom % 4194304, 8'(ai), 2'($urandom)};
        eb = {$urandom % 4194304, 8'(bi), 2'($urandom)};
        er = {$urandom % 4194304, 8'(ri), 2'($urandom)};
        @(negedge clk); #2;
        n_ar_a = 0; n_ar_b = 0; n_aw = 0; n_beats = 0; n_b = 0; n_done = 0;
        a_base = ea; b_base = eb; r_base = er; start = 1;
        @(negedge clk); #2;
        start = 0;
        a_base = $urandom; b_base = $urandom; r_base = $urandom;   // R1: must be ignored
        chk(idle == 1'b0, "R11 idle low while busy", {31'd0, idle}, 32'd0);
        if (!first) chk(irq == 1'b0, "R10 irq cleared by start", {31'd0, irq}, 32'd0);
        guard = 0;
        while (n_b == 0 && guard < 5000) begin @(negedge clk); #2; guard++; end
        @(negedge clk); #2;
        chk(idle == 1'b1, "R9 idle returns after done", {31'd0, idle}, 32'd1);
        chk(n_done == 1, "R9 done width", 32'(n_done), 32'd1);
        chk(irq == 1'b1, "R10 irq held", {31'd0, irq}, 32'd1);
        chk(n_ar_a == 1 && n_ar_b == 1, "R3 one request per read port", 32'(n_ar_a + n_ar_b), 32'd2);
        chk(n_aw == 1, "R4 one write request", 32'(n_aw), 32'd1);
        chk(n_beats == NUM, "R7 beat count", 32'(n_beats), 32'(NUM));
        chk(seen_a_addr == (ea & ~32'h3), "R1 R2 A address", seen_a_addr, ea & ~32'h3);
        chk(seen_b_addr == (eb & ~32'h3), "R1 R2 B address", seen_b_addr, eb & ~32'h3);
        chk(seen_r_addr == (er & ~32'h3), "R1 R2 result address", seen_r_addr, er & ~32'h3);
        for (int k = 0; k < NUM; k++)
            chk(mem_r[ri + k] == ref_mul(mem_a[ai + k], mem_b[bi + k]), "R6 R5 product",
                mem_r[ri + k], ref_mul(mem_a[ai + k], mem_b[bi + k]));
    endtask

    initial begin
        void'($urandom(32'd2024));
        for (int k = 0; k < 256; k++) begin mem_a[k] = 0; mem_b[k] = 0; mem_r[k] = 0; end
        n_ar_a = 0; n_ar_b = 0; n_aw = 0; n_beats = 0; n_b = 0; n_done = 0;
        seen_a_addr = 0; seen_b_addr = 0; seen_r_addr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R11 reset state
        chk(idle == 1'b1, "R11 idle after reset", {31'd0, idle}, 32'd1);
        chk(done == 1'b0 && irq == 1'b0, "R11 done/irq after reset", {30'd0, done, irq}, 32'd0);
        chk({a_arvalid, b_arvalid, r_awvalid, r_wvalid} == 4'd0, "R11 valids after reset",
            {28'd0, a_arvalid, b_arvalid, r_awvalid, r_wvalid}, 32'd0);
        // directed: zero-wait memory, then edge operands under random delays
        stress = 0; run_vec(0, 1'b1);
        stress = 1; run_vec(1, 1'b0);
        stress = 0; run_vec(1, 1'b0);
        // constrained random runs with random channel delays
        stress = 1;
        for (int t = 0; t < 12; t++) run_vec(2, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule